// File: doc/BRIEF.md
# Sticky Receiver Error Logger

This block sits behind a digital audio receiver front end and watches the error flags that arrive with each received frame: loss of lock, invalid sample, marginal eye opening, bi-phase coding violation, parity failure, and the two CRC failures for the Q-subcode and the channel-status block. A per-bit mask chooses which of these errors the block acts on. An unmasked error is latched into a sticky register. A host read of that register clears it. While any unmasked sticky bit is set, a level interrupt stays high.

The same mask also controls the audio path. When a frame carries an unmasked error of the first five kinds, its 24-bit sample is handled by a programmable policy: the previous output sample is repeated, the sample is replaced by zero, or the sample passes through unchanged. CRC errors never alter the sample. The host reaches the mask, the policy and the sticky register through a small two-address register port.

Top module: `rx_err_logger`

## Requirements
- R1: After reset the sticky register, the interrupt, the output sample, the output valid, the mask and the hold field are all zero.
- R2: Error bit positions are 0 unlock, 1 validity, 2 confidence, 3 bi-phase, 4 parity, 5 Q-subcode CRC, 6 channel-status CRC. An error flagged on a valid frame whose mask bit is 1 sets the matching sticky bit on the next clock. The bit stays set until the error register is read.
- R3: A read strobe with host_sel = 0 returns the sticky bits in host_rdata[6:0] (upper bits zero) in the same cycle, and clears them on the next clock. An unmasked error that arrives in the cycle of the read is still set afterwards.
- R4: An error whose mask bit is 0 is not logged, raises no interrupt and leaves the sample untouched.
- R5: irq is high exactly while some sticky bit is set whose mask bit is 1.
- R6: With hold = 00 a frame hit by an unmasked error in bits 0..4 outputs the previously output sample. That held value is zero after reset.
- R7: With hold = 01 such a frame outputs zero.
- R8: With hold = 10 or 11 such a frame outputs its own sample unchanged.
- R9: Errors in bits 5 and 6 never change the output sample, even when unmasked.
- R10: A write strobe with host_sel = 1 loads the mask from host_wdata[6:0] and the hold field from host_wdata[8:7]. A read with host_sel = 1 returns them in the same layout. A write with host_sel = 0 has no effect.
- R11: out_valid pulses one clock after frm_valid, and out_sample updates on that clock. Between frames out_sample holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A frame's sample and error flags are present |
| frm_err | input | 7 | Per-frame error flags |
| frm_sample | input | 24 | Received audio sample |
| host_sel | input | 1 | Register select: 0 error, 1 control |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 9 | Write data |
| host_rdata | output | 9 | Read data for the selected register |
| irq | output | 1 | Level error interrupt |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Sample after the substitution policy |

## Verification
On every cycle the assertions check several properties: that sticky bits do not drop without a read, that no sticky bit appears without an unmasked error behind it, that an unmasked error raises the interrupt, that a frame without a sample-affecting unmasked error passes unchanged, and that the zero policy produces zero. The bench shows what needs a sequence of cycles or a reference value. This covers the held sample carried across frames, a read that coincides with a new error, mask and policy changes in the middle of a run, and the writes to the error address that must be ignored.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned EW = 7;
  localparam int unsigned HW = 2;
  localparam int unsigned ERR_UNLOCK = 0;
  localparam int unsigned ERR_VALID  = 1;
  localparam int unsigned ERR_CONF   = 2;
  localparam int unsigned ERR_BIPH   = 3;
  localparam int unsigned ERR_PAR    = 4;
  localparam int unsigned ERR_QCRC   = 5;
  localparam int unsigned ERR_CCRC   = 6;
  localparam logic [EW-1:0] AUDIO_ERRS = 7'b001_1111;

  typedef enum logic [HW-1:0] {
    HOLD_PREV = 2'b00,
    HOLD_ZERO = 2'b01,
    HOLD_PASS = 2'b10,
    HOLD_PASS2 = 2'b11
  } hold_e;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rx_err_sticky.sv
module rx_err_sticky
  import rx_err_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [EW-1:0] frm_err,
  input  logic [EW-1:0] mask,
  input  logic          rd_clr,
  output logic [EW-1:0] sticky,
  output logic          irq
);
  logic [EW-1:0] hits;
  logic [EW-1:0] sticky_d;

  always_comb begin
    hits = frm_valid ? (frm_err & mask) : '0;
    if (rd_clr) sticky_d = hits;
    else        sticky_d = sticky | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= sticky_d;
  end

  assign irq = |(sticky & mask);

  // R2: without a read, set bits are never lost
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R4: a newly set bit always traces to an unmasked error on a valid frame
  a_r4_no_masked_log: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & ~$past(sticky) & ~({EW{$past(frm_valid)}} & $past(frm_err) & $past(mask))) == '0));
endmodule

// File: rtl/rx_sample_subst.sv
module rx_sample_subst
  import rx_err_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [EW-1:0] frm_err,
  input  logic [DW-1:0] frm_sample,
  input  logic [EW-1:0] mask,
  input  hold_e         hold,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  logic          hit;
  logic [DW-1:0] last_q;
  logic [DW-1:0] sample_d;

  always_comb begin
    hit = |(frm_err & mask & AUDIO_ERRS);
    sample_d = frm_sample;
    if (hit) begin
      unique case (hold)
        HOLD_PREV: sample_d = last_q;
        HOLD_ZERO: sample_d = '0;
        default:   sample_d = frm_sample;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      last_q     <= '0;
    end else begin
      out_valid <= frm_valid;
      if (frm_valid) begin
        out_sample <= sample_d;
        last_q     <= sample_d;
      end
    end
  end

  // R9: frames without a sample-affecting unmasked error pass through
  a_r9_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ((frm_err & mask & AUDIO_ERRS) == '0)) |=> (out_sample == $past(frm_sample)));

  // R7: the zero policy yields zero
  a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && hit && hold == HOLD_ZERO) |=> (out_sample == '0));

  // R11: output strobe follows input strobe by one clock
  a_r11_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> out_valid);
endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger
  import rx_err_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned RW = EW + HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [EW-1:0] frm_err,
  input  logic [DW-1:0] frm_sample,
  input  logic          host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [RW-1:0] host_wdata,
  output logic [RW-1:0] host_rdata,
  output logic          irq,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  logic          rst_s_n;
  logic [EW-1:0] mask_q, mask_d;
  hold_e         hold_q, hold_d;
  logic [EW-1:0] sticky;
  logic          ctrl_we;
  logic          rd_clr;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign ctrl_we = host_wr && host_sel;
  assign rd_clr  = host_rd && !host_sel;

  always_comb begin
    mask_d = mask_q;
    hold_d = hold_q;
    if (ctrl_we) begin
      mask_d = host_wdata[EW-1:0];
      hold_d = hold_e'(host_wdata[RW-1:EW]);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mask_q <= '0;
      hold_q <= HOLD_PREV;
    end else begin
      mask_q <= mask_d;
      hold_q <= hold_d;
    end
  end

  rx_err_sticky u_sticky (
    .clk(clk), .rst_n(rst_s_n), .frm_valid(frm_valid), .frm_err(frm_err),
    .mask(mask_q), .rd_clr(rd_clr), .sticky(sticky), .irq(irq)
  );

  rx_sample_subst #(.DW(DW)) u_subst (
    .clk(clk), .rst_n(rst_s_n), .frm_valid(frm_valid), .frm_err(frm_err),
    .frm_sample(frm_sample), .mask(mask_q), .hold(hold_q),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  assign host_rdata = host_sel ? {hold_q, mask_q} : {{HW{1'b0}}, sticky};

  // R5: an unmasked error with the mask stable leaves the interrupt raised
  a_r5_irq_raise: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frm_valid && |(frm_err & mask_q) && !ctrl_we) |=> irq);

  // R3: a read clears everything that did not arrive in the read cycle
  a_r3_read_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_clr && !frm_valid) |=> (sticky == '0));
endmodule

// File: tb/rx_err_logger_bench.sv
`timescale 1ns/1ps
module rx_err_logger_bench;
  localparam int DW = 24;
  localparam int EW = 7;
  localparam int RW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frm_valid = 1'b0;
  logic [EW-1:0] frm_err = '0;
  logic [DW-1:0] frm_sample = '0;
  logic          host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [RW-1:0] host_wdata = '0;
  logic [RW-1:0] host_rdata;
  logic          irq, out_valid;
  logic [DW-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [EW-1:0] m_st, m_mask;
  logic [1:0]    m_hold;
  logic [DW-1:0] m_out;
  logic          m_ov;
  string         out_tag;

  always #2.5 clk = ~clk;

  rx_err_logger u_rx_err_logger (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_err(frm_err),
    .frm_sample(frm_sample), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input logic [EW-1:0] e, input logic [EW-1:0] m,
                                          input logic [1:0] h, input logic [DW-1:0] s,
                                          input logic [DW-1:0] prev);
    if ((e & m & 7'h1f) == 0) return s;
    case (h)
      2'b00:   return prev;
      2'b01:   return '0;
      default: return s;
    endcase
  endfunction

  // compare outputs with model, then drive one cycle of stimulus and advance model
  task automatic step(input logic fv, input logic [EW-1:0] e, input logic [DW-1:0] s,
                      input logic sel, input logic rd, input logic wr, input logic [RW-1:0] wd);
    logic [EW-1:0] hits;
    chk("R11 out_valid", out_valid, m_ov);
    chk(out_tag, out_sample, m_out);
    chk("R5 irq", irq, |(m_st & m_mask));
    frm_valid = fv; frm_err = e; frm_sample = s;
    host_sel = sel; host_rd = rd; host_wr = wr; host_wdata = wd;
    #0.5;
    if (sel) chk("R10 ctrl readback", host_rdata, {m_hold, m_mask});
    else     chk("R3 sticky readback", host_rdata, {2'b00, m_st});
    hits = fv ? (e & m_mask) : '0;
    if (rd && !sel) m_st = hits; else m_st = m_st | hits;
    m_ov = fv;
    if (fv) begin
      if ((e & m_mask & 7'h1f) == 0) out_tag = ((e & m_mask) != 0) ? "R9 crc pass" : "R4 clean pass";
      else if (m_hold == 2'b00) out_tag = "R6 hold prev";
      else if (m_hold == 2'b01) out_tag = "R7 zero";
      else out_tag = "R8 pass";
      m_out = pick(e, m_mask, m_hold, s, m_out);
    end
    if (wr && sel) begin m_mask = wd[6:0]; m_hold = wd[8:7]; end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_st = '0; m_mask = '0; m_hold = 2'b00; m_out = '0; m_ov = 1'b0;
    out_tag = "R1 reset sample";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 irq", irq, 1'b0);
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 out_sample", out_sample, '0);
    chk("R1 sticky", host_rdata, '0);

    // R4: all masked, errors ignored
    step(1, 7'h7f, 24'h123456, 0, 0, 0, '0);
    step(0, '0, '0, 0, 0, 0, '0);
    // R10: write to error address ignored
    step(0, '0, '0, 0, 0, 1, 9'h1ff);
    step(0, '0, '0, 1, 1, 0, '0);
    // R10: program mask all, hold prev
    step(0, '0, '0, 1, 0, 1, {2'b00, 7'h7f});
    // R6: held value after reset is zero
    step(1, 7'h01, 24'hABCDEF, 0, 0, 0, '0);
    step(1, 7'h00, 24'h111111, 0, 0, 0, '0);
    step(1, 7'h08, 24'h222222, 0, 0, 0, '0);
    // R3: read coinciding with new error
    step(1, 7'h10, 24'h333333, 0, 1, 0, '0);
    step(0, '0, '0, 0, 0, 0, '0);
    step(0, '0, '0, 0, 1, 0, '0);
    step(0, '0, '0, 0, 0, 0, '0);
    // R9: CRC bits do not touch the sample, but log
    step(1, 7'h60, 24'h444444, 0, 0, 0, '0);
    // R7 zero policy
    step(0, '0, '0, 1, 0, 1, {2'b01, 7'h7f});
    step(1, 7'h04, 24'h555555, 0, 0, 0, '0);
    // R8 pass with 10 and 11
    step(0, '0, '0, 1, 0, 1, {2'b10, 7'h7f});
    step(1, 7'h02, 24'h666666, 0, 0, 0, '0);
    step(0, '0, '0, 1, 0, 1, {2'b11, 7'h7f});
    step(1, 7'h02, 24'h777777, 0, 0, 0, '0);
    // R5: masking a set bit drops irq
    step(0, '0, '0, 1, 0, 1, {2'b00, 7'h00});
    step(0, '0, '0, 0, 0, 0, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], (r[4:2] == 0) ? $urandom : 7'h00, $urandom,
           r[5], (r[8:6] == 0), (r[11:9] == 0), $urandom);
    end
    step(0, '0, '0, 0, 0, 0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule